// File: doc/BRIEF.md
# Monitor Identity Read Permission Decoder

This block decides the fate of a privileged read of a per-monitor identity register. A system can hold several performance monitors, and each one carries a 64-bit descriptor of the processors it is tied to. When software asks to read the descriptor of the monitor named by a select field, the block looks at the requesting privilege level and the control state of levels 2 and 3. It then gives exactly one verdict: the instruction is undefined, it traps to level 2, it traps to level 3, or the read goes ahead and returns the descriptor.

The decision is one fixed priority chain. Some level-3 denials can be raised ahead of every level-2 trap. Each per-monitor permission comes from a 2-bit field taken out of a packed control vector, and the monitor index chooses the field. The block is pure decode logic. Its verdict, syndrome and data are valid in the same cycle as the request strobe, and the exception entry itself happens elsewhere.

Top module: `spm_id_access`

## Requirements
- R1: While `req` is high exactly one of `res_undef`, `res_trap2`, `res_trap3`, `res_ok` is high. While `req` is low all four are low, `syn_class` is 0 and `rd_data` is 0.
- R2: A request with `cur_el` = 0 is always undefined.
- R3: A request at levels 1 to 3 whose `mon_sel` is at or above `NUM_MON` is undefined. This check comes ahead of every other check except R2.
- R4: A request at level 3 with a valid index is permitted, and `rd_data` returns bits [64s+63:64s] of `desc_tab`, where s = `mon_sel`.
- R5: A permission check uses bits [2s+1:2s] of its vector (`acc3_vec` or `acc2_vec`). The value 00 denies. The values 01, 10 and 11 allow.
- R6: At level 1 or 2, if `has_el3` and `promo_undef` are both high, then a low `el3_pm_en` or a denying `acc3_vec` field makes the request undefined before any other check.
- R7: At level 1 with `el2_en` high, the level-2 traps are tested next, in this order. First the fine-grained trap: `fgt_feat` is high and either (`has_el3` is high and `fgt3_en` is low) or `fgt_rd_allow` is low. Then a low `el2_pm_en`. Then a denying `acc2_vec` field. Any of these raises `res_trap2`.
- R8: After the level-2 checks, if `has_el3` is high, a low `el3_pm_en` or a denying `acc3_vec` field gives `res_undef` when `undef_sel` is high and `res_trap3` when it is low.
- R9: At level 2 no level-2 trap is ever raised. Only the checks of R6 and R8 apply, and if none hits, the read is permitted with the descriptor.
- R10: `syn_class` is 0x18 whenever a trap output is high and 0 otherwise. `rd_data` is 0 unless `res_ok` is high.
- R11: `virt_id` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the embedded checks |
| rst_n | input | 1 | Asynchronous active-low reset for the embedded checks |
| req | input | 1 | Read request strobe |
| cur_el | input | 2 | Privilege level of the requester (0 to 3) |
| has_el3 | input | 1 | Level 3 is implemented |
| el2_en | input | 1 | Level 2 is implemented and enabled |
| promo_undef | input | 1 | Raise level-3 denials to undefined ahead of level-2 traps |
| undef_sel | input | 1 | A level-3 denial gives undefined instead of a level-3 trap |
| el3_pm_en | input | 1 | Level-3 global monitor access enable |
| el2_pm_en | input | 1 | Level-2 monitor access enable |
| fgt_feat | input | 1 | Fine-grained trap feature present |
| fgt3_en | input | 1 | Level-3 enable for fine-grained traps |
| fgt_rd_allow | input | 1 | Per-register fine-grained read allow (0 traps) |
| acc3_vec | input | 2*NUM_MON | Level-3 per-monitor permission fields |
| acc2_vec | input | 2*NUM_MON | Level-2 per-monitor permission fields |
| mon_sel | input | SELW | Selected monitor index |
| desc_tab | input | DW*NUM_MON | Packed per-monitor descriptors |
| virt_id | input | DW | Virtual processor identity, ignored |
| res_undef | output | 1 | Verdict: undefined instruction |
| res_trap2 | output | 1 | Verdict: trap to level 2 |
| res_trap3 | output | 1 | Verdict: trap to level 3 |
| res_ok | output | 1 | Verdict: read permitted |
| syn_class | output | 6 | Trap syndrome class |
| rd_data | output | DW | Descriptor returned on a permitted read |

## Verification
All results are combinational: the verdict, the syndrome class and the data are due in the same cycle as the inputs that produce them, with no register on the way. The bench changes inputs on the falling clock edge and samples the outputs a quarter period later, before the next rising edge, so every sample sees settled logic for the stimulus just applied. The embedded checks sample on the rising edge, where the same stimulus is still held.

// File: rtl/spm_acc_pkg.sv
package spm_acc_pkg;
  localparam int SYN_W = 6;
  localparam logic [SYN_W-1:0] TRAP_CLASS = 6'h18;
  localparam logic [1:0] FIELD_DENY = 2'b00;

  typedef enum logic [1:0] {
    V_UNDEF = 2'd0,
    V_TRAP2 = 2'd1,
    V_TRAP3 = 2'd2,
    V_OK    = 2'd3
  } verdict_e;
endpackage

// File: rtl/spm_field_pick.sv
module spm_field_pick #(
  parameter int NUM_MON = 8,
  parameter int SELW    = 5
) (
  input  logic [2*NUM_MON-1:0] vec,
  input  logic [SELW-1:0]      sel,
  output logic [1:0]           fld
);
  logic [NUM_MON-1:0][1:0] hit_f;

  // one masked lane per monitor, OR-combined below
  for (genvar g = 0; g < NUM_MON; g++) begin : g_lane
    assign hit_f[g] = (sel == SELW'(g)) ? vec[2*g +: 2] : 2'b00;
  end

  always_comb begin
    fld = 2'b00;
    for (int i = 0; i < NUM_MON; i++) fld = fld | hit_f[i];
  end
endmodule

// File: rtl/spm_desc_mux.sv
module spm_desc_mux #(
  parameter int NUM_MON = 8,
  parameter int SELW    = 5,
  parameter int DW      = 64
) (
  input  logic [DW*NUM_MON-1:0] tab,
  input  logic [SELW-1:0]       sel,
  output logic [DW-1:0]         dout
);
  logic [NUM_MON-1:0][DW-1:0] lane;

  for (genvar g = 0; g < NUM_MON; g++) begin : g_lane
    assign lane[g] = (sel == SELW'(g)) ? tab[DW*g +: DW] : '0;
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < NUM_MON; i++) dout = dout | lane[i];
  end
endmodule

// File: rtl/spm_el3_gate.sv
module spm_el3_gate (
  input  logic       has_el3,
  input  logic       el3_pm_en,
  input  logic       promo_undef,
  input  logic [1:0] fld3,
  output logic       blk3,
  output logic       promo_hit
);
  import spm_acc_pkg::*;
  logic deny3;
  always_comb begin
    deny3     = (fld3 == FIELD_DENY);
    blk3      = has_el3 & (~el3_pm_en | deny3);
    promo_hit = blk3 & promo_undef;
  end
endmodule

// File: rtl/spm_el2_gate.sv
module spm_el2_gate (
  input  logic       el2_en,
  input  logic       has_el3,
  input  logic       fgt_feat,
  input  logic       fgt3_en,
  input  logic       fgt_rd_allow,
  input  logic       el2_pm_en,
  input  logic [1:0] fld2,
  output logic       trap2_hit
);
  import spm_acc_pkg::*;
  logic fgt_hit;
  always_comb begin
    fgt_hit   = fgt_feat & ((has_el3 & ~fgt3_en) | ~fgt_rd_allow);
    trap2_hit = el2_en & (fgt_hit | ~el2_pm_en | (fld2 == FIELD_DENY));
  end
endmodule

// File: rtl/spm_id_access.sv
module spm_id_access
  import spm_acc_pkg::*;
#(
  parameter int NUM_MON = 8,
  parameter int SELW    = 5,
  parameter int DW      = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [1:0]            cur_el,
  input  logic                  has_el3,
  input  logic                  el2_en,
  input  logic                  promo_undef,
  input  logic                  undef_sel,
  input  logic                  el3_pm_en,
  input  logic                  el2_pm_en,
  input  logic                  fgt_feat,
  input  logic                  fgt3_en,
  input  logic                  fgt_rd_allow,
  input  logic [2*NUM_MON-1:0]  acc3_vec,
  input  logic [2*NUM_MON-1:0]  acc2_vec,
  input  logic [SELW-1:0]       mon_sel,
  input  logic [DW*NUM_MON-1:0] desc_tab,
  input  logic [DW-1:0]         virt_id,
  output logic                  res_undef,
  output logic                  res_trap2,
  output logic                  res_trap3,
  output logic                  res_ok,
  output logic [SYN_W-1:0]      syn_class,
  output logic [DW-1:0]         rd_data
);
  localparam int MAXSEL = NUM_MON - 1;

  logic [1:0]    fld3, fld2;
  logic          blk3, promo_hit, trap2_hit;
  logic          idx_ok;
  logic [DW-1:0] sel_desc;
  verdict_e      verdict;
  logic          unused_virt;

  // R11: the virtual identity never enters the decision or data paths
  assign unused_virt = ^virt_id;

  spm_field_pick #(.NUM_MON(NUM_MON), .SELW(SELW)) u_pick3 (
    .vec(acc3_vec), .sel(mon_sel), .fld(fld3));
  spm_field_pick #(.NUM_MON(NUM_MON), .SELW(SELW)) u_pick2 (
    .vec(acc2_vec), .sel(mon_sel), .fld(fld2));

  spm_el3_gate u_el3 (
    .has_el3(has_el3), .el3_pm_en(el3_pm_en), .promo_undef(promo_undef),
    .fld3(fld3), .blk3(blk3), .promo_hit(promo_hit));

  spm_el2_gate u_el2 (
    .el2_en(el2_en), .has_el3(has_el3), .fgt_feat(fgt_feat),
    .fgt3_en(fgt3_en), .fgt_rd_allow(fgt_rd_allow), .el2_pm_en(el2_pm_en),
    .fld2(fld2), .trap2_hit(trap2_hit));

  spm_desc_mux #(.NUM_MON(NUM_MON), .SELW(SELW), .DW(DW)) u_desc (
    .tab(desc_tab), .sel(mon_sel), .dout(sel_desc));

  assign idx_ok = (mon_sel <= SELW'(MAXSEL));

  // priority chain
  always_comb begin
    verdict = V_OK;
    if (cur_el == 2'd0)        verdict = V_UNDEF;
    else if (!idx_ok)          verdict = V_UNDEF;
    else if (cur_el == 2'd3)   verdict = V_OK;
    else if (promo_hit)        verdict = V_UNDEF;
    else if (cur_el == 2'd1 && trap2_hit) verdict = V_TRAP2;
    else if (blk3)             verdict = undef_sel ? V_UNDEF : V_TRAP3;
    else                       verdict = V_OK;
  end

  always_comb begin
    res_undef = req & (verdict == V_UNDEF);
    res_trap2 = req & (verdict == V_TRAP2);
    res_trap3 = req & (verdict == V_TRAP3);
    res_ok    = req & (verdict == V_OK);
    syn_class = (res_trap2 | res_trap3) ? TRAP_CLASS : '0;
    rd_data   = res_ok ? sel_desc : '0;
  end

  // R1
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $countones({res_undef, res_trap2, res_trap3, res_ok}) == 1);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !(res_undef | res_trap2 | res_trap3 | res_ok));
  // R2
  el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cur_el == 2'd0) |-> res_undef);
  // R4
  el3_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cur_el == 2'd3 && mon_sel < SELW'(NUM_MON)) |-> res_ok);
  // R6
  promo_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (cur_el == 2'd1 || cur_el == 2'd2) && has_el3 && promo_undef
     && !el3_pm_en) |-> res_undef);
  // R9
  trap2_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_trap2 |-> (cur_el == 2'd1 && el2_en));
  // R8
  trap3_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_trap3 |-> (has_el3 && !undef_sel));
  // R10
  syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_trap2 || res_trap3) |-> syn_class == 6'h18);
  // R10
  data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ok |-> rd_data == '0);
endmodule

// File: tb/spm_id_access_test.sv
module spm_id_access_test;
  localparam int NM = 8;
  localparam int SW = 5;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic req;
  logic [1:0] cur_el;
  logic has_el3, el2_en, promo_undef, undef_sel, el3_pm_en, el2_pm_en;
  logic fgt_feat, fgt3_en, fgt_rd_allow;
  logic [2*NM-1:0] acc3_vec, acc2_vec;
  logic [SW-1:0] mon_sel;
  logic [DW*NM-1:0] desc_tab;
  logic [DW-1:0] virt_id;
  logic res_undef, res_trap2, res_trap3, res_ok;
  logic [5:0] syn_class;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  spm_id_access #(.NUM_MON(NM), .SELW(SW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .cur_el(cur_el),
    .has_el3(has_el3), .el2_en(el2_en), .promo_undef(promo_undef),
    .undef_sel(undef_sel), .el3_pm_en(el3_pm_en), .el2_pm_en(el2_pm_en),
    .fgt_feat(fgt_feat), .fgt3_en(fgt3_en), .fgt_rd_allow(fgt_rd_allow),
    .acc3_vec(acc3_vec), .acc2_vec(acc2_vec), .mon_sel(mon_sel),
    .desc_tab(desc_tab), .virt_id(virt_id),
    .res_undef(res_undef), .res_trap2(res_trap2), .res_trap3(res_trap3),
    .res_ok(res_ok), .syn_class(syn_class), .rd_data(rd_data));

  // expected verdict as {undef, trap2, trap3, ok}, plus the deciding requirement
  task automatic model(output logic [3:0] v, output string tag);
    logic [1:0] f3, f2;
    logic d3;
    int s;
    s = int'(mon_sel);
    if (!req) begin v = 4'b0000; tag = "R1"; return; end
    if (cur_el == 2'd0) begin v = 4'b1000; tag = "R2"; return; end
    if (s >= NM) begin v = 4'b1000; tag = "R3"; return; end
    if (cur_el == 2'd3) begin v = 4'b0001; tag = "R4"; return; end
    f3 = acc3_vec[2*s +: 2];
    f2 = acc2_vec[2*s +: 2];
    d3 = has_el3 && (!el3_pm_en || f3 == 2'b00);
    if (d3 && promo_undef) begin v = 4'b1000; tag = "R6"; return; end
    if (cur_el == 2'd1 && el2_en) begin
      if (fgt_feat && ((has_el3 && !fgt3_en) || !fgt_rd_allow)) begin
        v = 4'b0100; tag = "R7"; return;
      end
      if (!el2_pm_en) begin v = 4'b0100; tag = "R7"; return; end
      if (f2 == 2'b00) begin v = 4'b0100; tag = "R5"; return; end
    end
    if (d3) begin
      v = undef_sel ? 4'b1000 : 4'b0010; tag = "R8"; return;
    end
    v = 4'b0001;
    tag = (cur_el == 2'd2) ? "R9" : "R5";
  endtask

  task automatic check(input string extra);
    logic [3:0] ev, av;
    logic [5:0] es;
    logic [DW-1:0] ed;
    string tag;
    #5;
    model(ev, tag);
    es = (ev[2] | ev[1]) ? 6'h18 : 6'h00;
    ed = ev[0] ? desc_tab[DW*int'(mon_sel) +: DW] : '0;
    av = {res_undef, res_trap2, res_trap3, res_ok};
    checks++;
    if (av !== ev) begin
      fails++;
      $display("FAIL %s%s verdict actual=%b expected=%b", tag, extra, av, ev);
    end else if (syn_class !== es || rd_data !== ed) begin
      fails++;
      $display("FAIL R10 (%s%s) syn=%h/%h data=%h/%h", tag, extra,
               syn_class, es, rd_data, ed);
    end
  endtask

  task automatic base(input logic [1:0] el, input logic [SW-1:0] s);
    req = 1'b1; cur_el = el; mon_sel = s;
    has_el3 = 1; el2_en = 1; promo_undef = 0; undef_sel = 0;
    el3_pm_en = 1; el2_pm_en = 1; fgt_feat = 0; fgt3_en = 1; fgt_rd_allow = 1;
    acc3_vec = '1; acc2_vec = '1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] first_data;
    void'($urandom(32'd4242));
    for (int i = 0; i < NM; i++) desc_tab[DW*i +: DW] = {$urandom, $urandom};
    virt_id = 64'h0123_4567_89ab_cdef;
    base(2'd1, 0);
    req = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 idle state after reset
    @(negedge clk); check(" idle");
    // R2 level 0
    @(negedge clk); base(2'd0, 1); check(" el0");
    // R3 index bound, even at level 3
    @(negedge clk); base(2'd3, SW'(NM)); check(" sel=NUM_MON");
    @(negedge clk); base(2'd1, 5'd31); check(" sel=31");
    // R4 level 3 read despite all denials
    @(negedge clk); base(2'd3, 3); el3_pm_en = 0; acc3_vec = '0; check(" el3");
    // R6 promoted undefined beats a fine-grained trap
    @(negedge clk); base(2'd1, 2); promo_undef = 1; fgt_feat = 1; fgt_rd_allow = 0;
    acc3_vec[5:4] = 2'b00; check(" promo");
    // R7 fine-grained trap through level-3 fine-grain enable
    @(negedge clk); base(2'd1, 4); fgt_feat = 1; fgt3_en = 0; check(" fgt3");
    // R7 level-2 trap wins over non-promoted level-3 denial
    @(negedge clk); base(2'd1, 4); el2_pm_en = 0; el3_pm_en = 0; check(" pm2");
    // R5 denying level-2 field of monitor 6 only
    @(negedge clk); base(2'd1, 6); acc2_vec[13:12] = 2'b00; check(" f2deny");
    @(negedge clk); base(2'd1, 7); acc2_vec[13:12] = 2'b00; check(" neighbour");
    // R5 each allowing code
    for (int c = 1; c < 4; c++) begin
      @(negedge clk); base(2'd1, 0); acc2_vec[1:0] = 2'(c); acc3_vec[1:0] = 2'(c);
      check(" allow code");
    end
    // R8 undefined-or-trap choice
    @(negedge clk); base(2'd1, 1); acc3_vec[3:2] = 2'b00; undef_sel = 1; check(" usel1");
    @(negedge clk); base(2'd1, 1); acc3_vec[3:2] = 2'b00; undef_sel = 0; check(" usel0");
    @(negedge clk); base(2'd1, 1); has_el3 = 0; el3_pm_en = 0; check(" no el3");
    // R9 level 2 ignores level-2 controls
    @(negedge clk); base(2'd2, 5); el2_pm_en = 0; acc2_vec = '0; fgt_feat = 1;
    fgt_rd_allow = 0; check(" el2 self");
    @(negedge clk); base(2'd2, 5); el3_pm_en = 0; check(" el2 trap3");
    // R11 virtual identity has no effect
    @(negedge clk); base(2'd1, 2); virt_id = '0; check(" virt0");
    first_data = rd_data;
    @(negedge clk); virt_id = '1; check(" virt1");
    checks++;
    if (rd_data !== first_data) begin
      fails++;
      $display("FAIL R11 data actual=%h expected=%h", rd_data, first_data);
    end

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      req = ($urandom % 8) != 0;
      cur_el = 2'($urandom);
      mon_sel = (($urandom % 10) == 0) ? SW'($urandom) : SW'($urandom % NM);
      has_el3 = ($urandom % 4) != 0;
      el2_en = ($urandom % 3) != 0;
      promo_undef = ($urandom % 3) == 0;
      undef_sel = $urandom % 2;
      el3_pm_en = ($urandom % 5) != 0;
      el2_pm_en = ($urandom % 5) != 0;
      fgt_feat = $urandom % 2;
      fgt3_en = ($urandom % 4) != 0;
      fgt_rd_allow = ($urandom % 4) != 0;
      acc3_vec = 16'($urandom) | 16'($urandom);
      acc2_vec = 16'($urandom) | 16'($urandom);
      virt_id = {$urandom, $urandom};
      check(" random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule